// File: doc/BRIEF.md
# Firmware Load Command-Block Generator

This block turns a stream of firmware record headers into the chain of 32-bit command words that a DMA loader consumes. Each record is described by eight header bytes: a destination address and a byte count. The payload itself is carried elsewhere, so only the headers enter the block. For every record the block cuts the payload into chunks and emits one four-word command block per chunk. Each block holds a control word carrying the chunk length, the staging-buffer source address, the destination address and a checksum.

Payload is assumed to be laid out back to back in a series of fixed-size staging buffers. The block tracks which buffer is current and the write offset inside it. A chunk never crosses a buffer edge, never exceeds the maximum command length and never runs past its record. When the image ends, the block closes the chain with a single zero word. Running out of buffers halts the block with an error.

Headers are accepted one byte at a time on a valid/ready port. End of image is a separate valid/ready strobe. Command words leave on a valid/ready port, and back-pressure there simply stalls the generator.

Top module: `fwcb_gen`

## Requirements
- R1: A record header is eight bytes, least significant byte first: bytes 0 to 3 form the 32-bit destination address and bytes 4 to 7 form the 32-bit byte count. No payload bytes pass through the header port.
- R2: Every chunk length is the smallest of MAX_CMD_LEN (default 1024), the bytes still left in the record, and BUF_BYTES (default 4096) minus the current buffer offset.
- R3: Each chunk emits exactly four words, in this order: CTL_DEFAULT (default 32'h8C00_0000) ORed with the chunk length, the source address, the destination address, and the checksum.
- R4: The checksum word equals control XOR source XOR destination of the same block.
- R5: The source address is SRC_BASE (default 32'h0010_0000) plus buffer index times BUF_BYTES plus the buffer offset. After a chunk, the destination and the offset both grow by the chunk length, and the destination wraps modulo 2^32.
- R6: When the current buffer is full and the record still has bytes, the next buffer is opened with its offset at zero. A buffer is never opened while no byte needs it.
- R7: At most BUF_COUNT (default 64) buffers are used. Needing one more raises err_o. From then until reset, no further word is emitted and no input is accepted.
- R8: A record with a byte count of zero emits no command block.
- R9: End of image is accepted only between records, that is, in header collection with no header byte of the current record taken. It then emits one zero word and restarts the next image at buffer 0, offset 0. When a header byte and end of image are both offered at that point, end of image wins and the byte is not taken.
- R10: While cmd_valid_o is high and cmd_ready_i is low, the output word is held unchanged, and no word is lost or repeated. Neither input port is ready while words are being emitted.
- R11: After reset, cmd_valid_o and err_o are low, and hdr_ready_o and eoi_ready_o are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid_i | input | 1 | Header byte offered |
| hdr_byte_i | input | 8 | Header byte, least significant first |
| hdr_ready_o | output | 1 | Header byte accepted this cycle when valid |
| eoi_valid_i | input | 1 | End of image offered |
| eoi_ready_o | output | 1 | End of image accepted this cycle when valid |
| cmd_valid_o | output | 1 | Command word available |
| cmd_word_o | output | 32 | Command word |
| cmd_ready_i | input | 1 | Downstream takes the word |
| err_o | output | 1 | Staging buffers exhausted; block halted |

## Verification
A wrong buffer index or offset shows up in the very next source address. It also corrupts that block's checksum, so the fault is visible within the same four-word block. A wrong length count or header byte order misplaces every later chunk of the record, and a wrong block boundary shifts every following word against the expected sequence. A stall or precedence fault drops, repeats or misaligns words. It is exposed by the end-of-image compare of the whole chain, including the terminator, under a ready pattern that stalls on a third of the cycles.

// File: rtl/fwcb_pkg.sv
package fwcb_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        ST_HDR,
        ST_PLAN,
        ST_EMIT,
        ST_TERM,
        ST_HALT
    } fwcb_state_e;

    typedef enum logic [1:0] {
        W_CTL = 2'd0,
        W_SRC = 2'd1,
        W_DST = 2'd2,
        W_SUM = 2'd3
    } fwcb_word_e;

endpackage

// File: rtl/fwcb_hdr_asm.sv
module fwcb_hdr_asm
    import fwcb_pkg::*;
#(
    parameter int HDR_BYTES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  take_i,
    input  logic [7:0]            byte_i,
    output logic                  at_start_o,
    output logic                  done_o,
    output logic [WORD_W-1:0]     dst_o,
    output logic [WORD_W-1:0]     len_o
);
    localparam int CNT_W = $clog2(HDR_BYTES);
    localparam int SH_W  = 8 * HDR_BYTES;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SH_W-1:0]  sh;
    } asm_t;

    asm_t q, d;
    logic [SH_W-1:0] sh_next;

    always_comb begin
        d       = q;
        // bytes enter at the top and drift down, so byte 0 ends at bit 0
        sh_next = {byte_i, q.sh[SH_W-1:8]};
        if (take_i) begin
            d.sh  = sh_next;
            d.cnt = (q.cnt == CNT_W'(HDR_BYTES - 1)) ? '0 : q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt <= '0;
            q.sh  <= '0;
        end else begin
            q <= d;
        end
    end

    assign at_start_o = (q.cnt == '0);
    assign done_o     = take_i && (q.cnt == CNT_W'(HDR_BYTES - 1));
    assign dst_o      = sh_next[WORD_W-1:0];
    assign len_o      = sh_next[2*WORD_W-1:WORD_W];

    AST_HDR_COUNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> at_start_o) else $error("header count did not wrap"); // R1

endmodule

// File: rtl/fwcb_chunk_sizer.sv
module fwcb_chunk_sizer
    import fwcb_pkg::*;
#(
    parameter int BUF_BYTES   = 4096,
    parameter int MAX_CMD_LEN = 1024,
    parameter int OFF_W       = 13
) (
    input  logic [WORD_W-1:0] rem_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic [WORD_W-1:0] clen_o
);
    logic [WORD_W-1:0] room;
    logic [WORD_W-1:0] cap;

    always_comb begin
        room   = WORD_W'(BUF_BYTES) - WORD_W'(off_i);
        cap    = (rem_i < WORD_W'(MAX_CMD_LEN)) ? rem_i : WORD_W'(MAX_CMD_LEN);
        clen_o = (cap < room) ? cap : room;
    end

endmodule

// File: rtl/fwcb_word_sel.sv
module fwcb_word_sel
    import fwcb_pkg::*;
(
    input  fwcb_word_e        sel_i,
    input  logic              term_i,
    input  logic [WORD_W-1:0] ctl_i,
    input  logic [WORD_W-1:0] src_i,
    input  logic [WORD_W-1:0] dst_i,
    output logic [WORD_W-1:0] word_o
);
    always_comb begin
        if (term_i) begin
            word_o = '0;
        end else begin
            unique case (sel_i)
                W_CTL:   word_o = ctl_i;
                W_SRC:   word_o = src_i;
                W_DST:   word_o = dst_i;
                default: word_o = ctl_i ^ src_i ^ dst_i;
            endcase
        end
    end

endmodule

// File: rtl/fwcb_gen.sv
module fwcb_gen
    import fwcb_pkg::*;
#(
    parameter logic [31:0] SRC_BASE    = 32'h0010_0000,
    parameter int          BUF_BYTES   = 4096,
    parameter int          BUF_COUNT   = 64,
    parameter int          MAX_CMD_LEN = 1024,
    parameter logic [31:0] CTL_DEFAULT = 32'h8C00_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hdr_valid_i,
    input  logic [7:0]  hdr_byte_i,
    output logic        hdr_ready_o,
    input  logic        eoi_valid_i,
    output logic        eoi_ready_o,
    output logic        cmd_valid_o,
    output logic [31:0] cmd_word_o,
    input  logic        cmd_ready_i,
    output logic        err_o
);
    localparam int IDX_W = (BUF_COUNT > 1) ? $clog2(BUF_COUNT) : 1;
    localparam int OFF_W = $clog2(BUF_BYTES + 1);

    typedef struct packed {
        fwcb_state_e       state;
        logic [IDX_W-1:0]  idx;
        logic [OFF_W-1:0]  off;
        logic [WORD_W-1:0] dst;
        logic [WORD_W-1:0] rem;
        logic [WORD_W-1:0] clen;
        fwcb_word_e        wsel;
    } gen_t;

    gen_t q, d;

    logic              hdr_at_start;
    logic              hdr_done;
    logic [WORD_W-1:0] hdr_dst;
    logic [WORD_W-1:0] hdr_len;
    logic              hdr_take;
    logic [WORD_W-1:0] next_clen;
    logic [WORD_W-1:0] src_addr;
    logic [WORD_W-1:0] ctl_word;
    logic              buf_full;
    logic              last_buf;

    fwcb_hdr_asm #(.HDR_BYTES(8)) u_hdr (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_i     (hdr_take),
        .byte_i     (hdr_byte_i),
        .at_start_o (hdr_at_start),
        .done_o     (hdr_done),
        .dst_o      (hdr_dst),
        .len_o      (hdr_len)
    );

    fwcb_chunk_sizer #(
        .BUF_BYTES   (BUF_BYTES),
        .MAX_CMD_LEN (MAX_CMD_LEN),
        .OFF_W       (OFF_W)
    ) u_sizer (
        .rem_i  (q.rem),
        .off_i  (q.off),
        .clen_o (next_clen)
    );

    assign src_addr = SRC_BASE + WORD_W'(q.idx) * WORD_W'(BUF_BYTES) + WORD_W'(q.off);
    assign ctl_word = CTL_DEFAULT | q.clen;
    assign buf_full = (q.off == OFF_W'(BUF_BYTES));
    assign last_buf = (q.idx == IDX_W'(BUF_COUNT - 1));

    fwcb_word_sel u_sel (
        .sel_i  (q.wsel),
        .term_i (q.state == ST_TERM),
        .ctl_i  (ctl_word),
        .src_i  (src_addr),
        .dst_i  (q.dst),
        .word_o (cmd_word_o)
    );

    // end of image wins over a header byte at a record boundary
    assign eoi_ready_o = (q.state == ST_HDR) && hdr_at_start;
    assign hdr_ready_o = (q.state == ST_HDR) && !(hdr_at_start && eoi_valid_i);
    assign hdr_take    = hdr_valid_i && hdr_ready_o;
    assign cmd_valid_o = (q.state == ST_EMIT) || (q.state == ST_TERM);
    assign err_o       = (q.state == ST_HALT);

    always_comb begin
        d = q;
        unique case (q.state)
            ST_HDR: begin
                if (eoi_valid_i && eoi_ready_o) begin
                    d.state = ST_TERM;
                end else if (hdr_done) begin
                    d.dst   = hdr_dst;
                    d.rem   = hdr_len;
                    d.state = ST_PLAN;
                end
            end
            ST_PLAN: begin
                if (q.rem == '0) begin
                    d.state = ST_HDR;
                end else if (buf_full) begin
                    if (last_buf) begin
                        d.state = ST_HALT;
                    end else begin
                        d.idx = q.idx + 1'b1;
                        d.off = '0;
                    end
                end else begin
                    d.clen  = next_clen;
                    d.wsel  = W_CTL;
                    d.state = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (cmd_ready_i) begin
                    if (q.wsel == W_SUM) begin
                        d.off   = q.off + q.clen[OFF_W-1:0];
                        d.dst   = q.dst + q.clen;
                        d.rem   = q.rem - q.clen;
                        d.state = ST_PLAN;
                    end else begin
                        d.wsel = fwcb_word_e'(q.wsel + 2'd1);
                    end
                end
            end
            ST_TERM: begin
                if (cmd_ready_i) begin
                    d.idx   = '0;
                    d.off   = '0;
                    d.state = ST_HDR;
                end
            end
            default: begin
                d.state = ST_HALT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_HDR;
            q.idx   <= '0;
            q.off   <= '0;
            q.dst   <= '0;
            q.rem   <= '0;
            q.clen  <= '0;
            q.wsel  <= W_CTL;
        end else begin
            q <= d;
        end
    end

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_word_o)))
        else $error("word changed under back-pressure"); // R10

    AST_PORTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> (!hdr_ready_o && !eoi_ready_o))
        else $error("input ready while emitting"); // R10

    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> (err_o && !cmd_valid_o && !hdr_ready_o && !eoi_ready_o))
        else $error("activity after buffer exhaustion"); // R7

    AST_OFF_IN_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        q.off <= OFF_W'(BUF_BYTES))
        else $error("buffer offset beyond buffer"); // R6

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(q.idx) < 32'(BUF_COUNT))
        else $error("buffer index beyond limit"); // R7

endmodule

// File: tb/fwcb_gen_tb.sv
module fwcb_gen_tb;

    localparam logic [31:0] SB   = 32'h0010_0000;
    localparam int          BUF  = 4096;
    localparam int          CNT  = 64;
    localparam int          MAXL = 1024;
    localparam logic [31:0] CTL  = 32'h8C00_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_valid_i = 1'b0;
    logic [7:0]  hdr_byte_i = '0;
    logic        hdr_ready_o;
    logic        eoi_valid_i = 1'b0;
    logic        eoi_ready_o;
    logic        cmd_valid_o;
    logic [31:0] cmd_word_o;
    logic        cmd_ready_i = 1'b1;
    logic        err_o;

    fwcb_gen #(
        .SRC_BASE(SB), .BUF_BYTES(BUF), .BUF_COUNT(CNT),
        .MAX_CMD_LEN(MAXL), .CTL_DEFAULT(CTL)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .hdr_valid_i(hdr_valid_i), .hdr_byte_i(hdr_byte_i), .hdr_ready_o(hdr_ready_o),
        .eoi_valid_i(eoi_valid_i), .eoi_ready_o(eoi_ready_o),
        .cmd_valid_o(cmd_valid_o), .cmd_word_o(cmd_word_o), .cmd_ready_i(cmd_ready_i),
        .err_o(err_o)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic bp_mode = 1'b0;

    logic [31:0] got   [0:2047];
    logic [31:0] exp_w [0:2047];
    int ngot = 0;
    int nexp = 0;

    int m_idx = 0;
    int m_off = 0;
    bit m_err = 1'b0;

    // {dst, len, end image after this record, back-pressure}
    localparam int NV = 6;
    localparam logic [65:0] VEC [NV] = '{
        {32'h0001_0000, 32'd100,  1'b0, 1'b0},
        {32'h0002_0000, 32'd0,    1'b0, 1'b0},
        {32'h0003_0000, 32'd3000, 1'b1, 1'b0},
        {32'h4000_0000, 32'd1000, 1'b0, 1'b1},
        {32'h4010_0000, 32'd5000, 1'b1, 1'b1},
        {32'hFFFF_FC00, 32'd2048, 1'b1, 1'b1}
    };

    always @(negedge clk) begin
        cyc <= cyc + 1;
        cmd_ready_i = bp_mode ? ((cyc % 3) != 1) : 1'b1;
    end

    always begin
        @(negedge clk);
        #4;
        if (cmd_valid_o && cmd_ready_i) begin
            if (ngot < 2048) got[ngot] = cmd_word_o;
            ngot = ngot + 1;
        end
    end

    always @(negedge clk) begin
        if (cyc > 150000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %h expected %h", what, act, expv);
        end
    endtask

    task automatic push(input logic [31:0] w);
        exp_w[nexp] = w;
        nexp = nexp + 1;
    endtask

    // expected chain built from R2..R8
    task automatic model_rec(input logic [31:0] dst, input logic [31:0] len);
        logic [31:0] dd, ll, c, cw, sw;
        dd = dst;
        ll = len;
        while (ll != 0 && !m_err) begin
            if (m_off == BUF) begin
                if (m_idx == CNT - 1) m_err = 1'b1;
                else begin
                    m_idx = m_idx + 1;
                    m_off = 0;
                end
            end
            if (!m_err) begin
                c = 32'(MAXL);
                if (ll < c) c = ll;
                if (32'(BUF - m_off) < c) c = 32'(BUF - m_off);
                cw = CTL | c;
                sw = SB + 32'(m_idx) * 32'(BUF) + 32'(m_off);
                push(cw); push(sw); push(dd); push(cw ^ sw ^ dd);
                m_off = m_off + int'(c);
                dd = dd + c;
                ll = ll - c;
            end
        end
    endtask

    task automatic model_eoi();
        push(32'h0);
        m_idx = 0;
        m_off = 0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        hdr_valid_i = 1'b1;
        hdr_byte_i  = b;
        #4;
        while (!hdr_ready_o) begin
            @(negedge clk);
            #4;
        end
        @(posedge clk);
        #1;
        hdr_valid_i = 1'b0;
    endtask

    task automatic send_rec(input logic [31:0] dst, input logic [31:0] len);
        for (int k = 0; k < 4; k++) send_byte(dst[8*k +: 8]);
        for (int k = 0; k < 4; k++) send_byte(len[8*k +: 8]);
    endtask

    task automatic send_eoi();
        @(negedge clk);
        eoi_valid_i = 1'b1;
        #4;
        while (!eoi_ready_o) begin
            @(negedge clk);
            #4;
        end
        @(posedge clk);
        #1;
        eoi_valid_i = 1'b0;
    endtask

    task automatic drain();
        int k;
        k = 0;
        while (ngot < nexp && k < 6000) begin
            @(negedge clk);
            k = k + 1;
        end
        repeat (12) @(negedge clk);
    endtask

    task automatic compare(input string tag);
        int bad;
        bad = -1;
        check(ngot == nexp, {tag, " word count"}, 32'(ngot), 32'(nexp));
        for (int k = 0; k < nexp && k < ngot; k++)
            if (bad < 0 && got[k] !== exp_w[k]) bad = k;
        if (bad >= 0) check(1'b0, $sformatf("%s word %0d", tag, bad), got[bad], exp_w[bad]);
        else check(1'b1, tag, 32'h0, 32'h0);
        ngot = 0;
        nexp = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_idx = 0; m_off = 0; m_err = 1'b0;
        ngot = 0; nexp = 0;
        @(negedge clk);
    endtask

    task automatic check_reset_state();
        #4;
        check(!cmd_valid_o, "R11 cmd_valid after reset", 32'(cmd_valid_o), 32'h0);
        check(!err_o, "R11 err after reset", 32'(err_o), 32'h0);
        check(hdr_ready_o && eoi_ready_o, "R11 input ready after reset",
              {30'h0, hdr_ready_o, eoi_ready_o}, 32'h3);
    endtask

    initial begin
        do_reset();
        check_reset_state();

        // table: R1 byte order, R2 splits, R3/R4 block words, R5 addresses,
        // R6 buffer step, R8 zero-length record, R10 under back-pressure
        for (int i = 0; i < NV; i++) begin
            bp_mode = VEC[i][0];
            model_rec(VEC[i][65:34], VEC[i][33:2]);
            send_rec(VEC[i][65:34], VEC[i][33:2]);
            if (VEC[i][1]) begin
                model_eoi();
                send_eoi();
                drain();
                compare($sformatf("R2 R3 R4 R5 R6 R8 R10 image ending at vector %0d", i));
            end
        end

        // R9: empty image gives only the terminator
        bp_mode = 1'b0;
        model_eoi();
        send_eoi();
        drain();
        compare("R9 empty image");

        // R8: lone zero-length record then end
        model_rec(32'h1234_5678, 32'd0);
        send_rec(32'h1234_5678, 32'd0);
        model_eoi();
        send_eoi();
        drain();
        compare("R8 zero-length record");

        // R9: end of image beats a header byte at a boundary
        @(negedge clk);
        hdr_valid_i = 1'b1;
        hdr_byte_i  = 8'h55;
        eoi_valid_i = 1'b1;
        #4;
        check(!hdr_ready_o && eoi_ready_o, "R9 precedence readies",
              {30'h0, hdr_ready_o, eoi_ready_o}, 32'h1);
        @(posedge clk);
        #1;
        hdr_valid_i = 1'b0;
        eoi_valid_i = 1'b0;
        model_eoi();
        model_rec(32'h5000_0000, 32'd16);
        send_rec(32'h5000_0000, 32'd16);
        model_eoi();
        send_eoi();
        drain();
        compare("R9 precedence then record");

        // R6/R7: exactly all buffers filled is legal
        bp_mode = 1'b1;
        model_rec(32'h6000_0000, 32'(BUF * CNT));
        send_rec(32'h6000_0000, 32'(BUF * CNT));
        model_eoi();
        send_eoi();
        drain();
        compare("R7 exact fill");
        check(!err_o, "R7 no error on exact fill", 32'(err_o), 32'h0);

        // R7: one byte more needs another buffer
        bp_mode = 1'b0;
        model_rec(32'h7000_0000, 32'(BUF * CNT + 1));
        send_rec(32'h7000_0000, 32'(BUF * CNT + 1));
        drain();
        compare("R7 overflow chain");
        #4;
        check(err_o == 1'b1, "R7 error raised", 32'(err_o), 32'h1);
        check(!hdr_ready_o && !eoi_ready_o && !cmd_valid_o, "R7 halted ports",
              {29'h0, hdr_ready_o, eoi_ready_o, cmd_valid_o}, 32'h0);

        do_reset();
        check_reset_state();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule